// File: doc/BRIEF.md
# EEPROM Page Write Sequencer

This block sits between the serial bus engine of an EEPROM and its memory array. It manages the write path. When a write command starts, the bus engine passes on the base word address. Each data byte then lands in a small page buffer, at an offset that steps through the low address bits and wraps inside the page. The upper address bits never change during the command.

When a stop condition closes the command, the buffered bytes are committed to the array. Only the offsets that actually received data are written, and the write-protect input must be low at the stop. The block then holds `busy` for a write-cycle time given in clock cycles. It also hands the address of the last byte written to the address counter, so the next current-address read starts there.

An abort (a repeated start with no stop) throws the buffer away. A new start-write during collection also throws the buffer away. While `busy` is high, every bus-side input is ignored.

Top module: `page_write_seq`

## Requirements
- R1: After `wr_start` with base address A, each `byte_vld` byte is stored at word address {A[ADDR_W-1:4], offset}, with the offset starting at A[3:0] and rising by one per byte. On a stop, each stored byte is driven once on `arr_we`/`arr_addr`/`arr_data`.
- R2: The 4-bit offset wraps from 15 to 0. The upper address bits stay those of A, so no write ever leaves the page.
- R3: No array write happens before the stop. `arr_we` is only ever high while `busy` is high.
- R4: If `wp` is high in the stop cycle, nothing is written, `busy` stays low and `addr_load` is not pulsed.
- R5: After an accepted stop, `busy` rises on the next cycle and stays high for exactly WR_CYCLES cycles.
- R6: `abort` during collection discards all received bytes. A stop that follows writes nothing.
- R7: With an accepted stop, `addr_load` pulses for one cycle, in the cycle `busy` rises. `last_addr` then gives the address of the last byte received.
- R8: If more than 16 bytes arrive, later bytes overwrite the earlier bytes at the same offset. Each offset is still written only once, with its newest byte.
- R9: Offsets that received no byte are not written, and their array contents are kept. Commit writes go out in ascending offset order.
- R10: While `busy` is high, `wr_start`, `byte_vld`, `stop` and `abort` have no effect.
- R11: `wr_start` during collection discards the bytes so far and restarts with the new base address.
- R12: A stop with no data byte received writes nothing and leaves `busy` low.
- R13: After reset, `busy`, `arr_we` and `addr_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Write command begins (one-cycle pulse) |
| wr_base | input | ADDR_W | Base word address for the command |
| byte_vld | input | 1 | A data byte is present on `byte_data` |
| byte_data | input | DATA_W | Received data byte |
| stop | input | 1 | Stop condition ends the command |
| abort | input | 1 | Repeated start without stop; discard |
| wp | input | 1 | Write protect, high blocks the commit |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |
| busy | output | 1 | Internal write cycle in progress |
| addr_load | output | 1 | One-cycle pulse: load `last_addr` into the address counter |
| last_addr | output | ADDR_W | Address of the last byte written |

## Verification
The bound checker watches several rules on every cycle:
- array writes happen only while `busy` is high;
- writes that follow one another stay in one page and go in ascending offset order;
- `busy` rises only after a stop with `wp` low, and every busy window lasts exactly WR_CYCLES cycles;
- a protected stop raises nothing;
- `addr_load` coincides with the rise of `busy`.

The directed scenarios show what only end-to-end data can show: the wrap addresses, overwriting past 16 bytes, the untouched neighbouring bytes, the discard on abort and on restart, and the inputs ignored during busy. The bench compares a model array and the write count against values it computes from the requirements.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_COMMIT  = 2'd2,
    ST_WAIT    = 2'd3
  } pgw_state_e;
endpackage

// File: rtl/pgw_page_buf.sv
// Page buffer: one data register and one valid flag per offset.
module pgw_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [OFS_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFS_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  logic [DATA_W-1:0] data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_ent
    logic hit;
    assign hit = we && (wr_idx == OFS_W'(i));

    always_ff @(posedge clk) begin
      if (hit) data_q[i] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q[i] <= 1'b0;
      else if (clr)   vld_q[i] <= 1'b0;
      else if (hit)   vld_q[i] <= 1'b1;
    end
  end

  assign rd_data = data_q[rd_idx];
  assign rd_vld  = vld_q[rd_idx];
endmodule

// File: rtl/pgw_wr_timer.sv
// Write-cycle timer: busy for exactly WR_CYCLES cycles after a load.
module pgw_wr_timer #(
  parameter int WR_CYCLES = 1000000,
  localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = CNT_W'(WR_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pgw_ctrl.sv
// Command sequencer: collect, commit scan, wait for the timer.
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int HI_W      = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              byte_vld,
  input  logic              stop,
  input  logic              abort,
  input  logic              wp,
  input  logic              tmr_last,
  input  logic              rd_vld,
  output logic              buf_clr,
  output logic              buf_we,
  output logic [OFS_W-1:0]  buf_wr_idx,
  output logic [OFS_W-1:0]  buf_rd_idx,
  output logic              tmr_load,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              addr_load,
  output logic [ADDR_W-1:0] last_addr
);
  pgw_state_e        state_q, state_d;
  logic [HI_W-1:0]   page_q, page_d;
  logic [OFS_W-1:0]  ptr_q, ptr_d;
  logic [OFS_W-1:0]  lptr_q, lptr_d;
  logic [OFS_W-1:0]  idx_q, idx_d;
  logic              any_q, any_d;
  logic              load_q, load_d;
  logic [ADDR_W-1:0] laddr_q, laddr_d;

  always_comb begin
    state_d  = state_q;
    page_d   = page_q;
    ptr_d    = ptr_q;
    lptr_d   = lptr_q;
    idx_d    = idx_q;
    any_d    = any_q;
    load_d   = 1'b0;
    laddr_d  = laddr_q;
    buf_clr  = 1'b0;
    buf_we   = 1'b0;
    tmr_load = 1'b0;
    arr_we   = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_COLLECT: begin
        if (wr_start) begin
          state_d = ST_COLLECT;
          page_d  = wr_base[ADDR_W-1:OFS_W];
          ptr_d   = wr_base[OFS_W-1:0];
          any_d   = 1'b0;
          buf_clr = 1'b1;
        end else if (state_q == ST_COLLECT) begin
          if (abort) begin
            state_d = ST_IDLE;
          end else if (stop) begin
            if (any_q && !wp) begin
              state_d  = ST_COMMIT;
              idx_d    = '0;
              tmr_load = 1'b1;
              load_d   = 1'b1;
              laddr_d  = {page_q, lptr_q};
            end else begin
              state_d = ST_IDLE;
            end
          end else if (byte_vld) begin
            buf_we = 1'b1;
            lptr_d = ptr_q;
            ptr_d  = ptr_q + 1'b1;
            any_d  = 1'b1;
          end
        end
      end
      ST_COMMIT: begin
        arr_we = rd_vld;
        idx_d  = idx_q + 1'b1;
        if (idx_q == OFS_W'(PAGE_BYTES - 1)) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (tmr_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      ptr_q   <= '0;
      lptr_q  <= '0;
      idx_q   <= '0;
      any_q   <= 1'b0;
      load_q  <= 1'b0;
      laddr_q <= '0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      ptr_q   <= ptr_d;
      lptr_q  <= lptr_d;
      idx_q   <= idx_d;
      any_q   <= any_d;
      load_q  <= load_d;
      laddr_q <= laddr_d;
    end
  end

  assign buf_wr_idx = ptr_q;
  assign buf_rd_idx = idx_q;
  assign arr_addr   = {page_q, idx_q};
  assign addr_load  = load_q;
  assign last_addr  = laddr_q;
endmodule

// File: rtl/page_write_seq.sv
// Top: reset release synchronizer, sequencer, page buffer, timer.
module page_write_seq #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 1000000,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop,
  input  logic              abort,
  input  logic              wp,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy,
  output logic              addr_load,
  output logic [ADDR_W-1:0] last_addr
);
  logic [1:0]       rst_sync_q;
  logic             srst_n;
  logic             buf_clr, buf_we, rd_vld, tmr_load, tmr_last;
  logic [OFS_W-1:0] buf_wr_idx, buf_rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  pgw_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) ctrl_i (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_start   (wr_start),
    .wr_base    (wr_base),
    .byte_vld   (byte_vld),
    .stop       (stop),
    .abort      (abort),
    .wp         (wp),
    .tmr_last   (tmr_last),
    .rd_vld     (rd_vld),
    .buf_clr    (buf_clr),
    .buf_we     (buf_we),
    .buf_wr_idx (buf_wr_idx),
    .buf_rd_idx (buf_rd_idx),
    .tmr_load   (tmr_load),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .addr_load  (addr_load),
    .last_addr  (last_addr)
  );

  pgw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) buf_i (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (buf_clr),
    .we      (buf_we),
    .wr_idx  (buf_wr_idx),
    .wr_data (byte_data),
    .rd_idx  (buf_rd_idx),
    .rd_data (arr_data),
    .rd_vld  (rd_vld)
  );

  pgw_wr_timer #(.WR_CYCLES(WR_CYCLES)) tmr_i (
    .clk   (clk),
    .rst_n (srst_n),
    .load  (tmr_load),
    .busy  (busy),
    .last  (tmr_last)
  );
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
  parameter int ADDR_W    = 11,
  parameter int OFS_W     = 4,
  parameter int WR_CYCLES = 1000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop,
  input logic              wp,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              addr_load
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 32'd1;
    else           run_q <= '0;
  end

  p_write_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  p_same_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |->
      arr_addr[ADDR_W-1:OFS_W] == $past(arr_addr[ADDR_W-1:OFS_W]));

  p_ascending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |->
      arr_addr[OFS_W-1:0] > $past(arr_addr[OFS_W-1:0]));

  p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop) && !$past(wp)));

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> run_q == 32'(WR_CYCLES));

  p_protect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && wp && !busy) |=> (!busy && !addr_load));

  p_load_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |-> $rose(busy));
endmodule

bind page_write_seq pgw_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .WR_CYCLES(WR_CYCLES)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop      (stop),
  .wp        (wp),
  .busy      (busy),
  .arr_we    (arr_we),
  .arr_addr  (arr_addr),
  .addr_load (addr_load)
);

// File: tb/page_write_seq_tb_top.sv
`timescale 1ns/1ps
module page_write_seq_tb_top;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int WRC = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_start, byte_vld, stop, abort, wp;
  logic [AW-1:0] wr_base;
  logic [DW-1:0] byte_data;
  logic          arr_we, busy, addr_load;
  logic [AW-1:0] arr_addr, last_addr;
  logic [DW-1:0] arr_data;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int busy_cyc = 0;
  int load_cnt = 0;
  logic [AW-1:0] cap_last;
  logic [DW-1:0] mem_m [2**AW];

  always #2 clk = ~clk;

  page_write_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(16), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_base(wr_base),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop(stop), .abort(abort),
    .wp(wp), .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
    .busy(busy), .addr_load(addr_load), .last_addr(last_addr)
  );

  // Model array and event log, sampled away from the rising edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (arr_we) begin
        mem_m[arr_addr] <= arr_data;
        wr_cnt <= wr_cnt + 1;
      end
      if (busy) busy_cyc <= busy_cyc + 1;
      if (addr_load) begin
        load_cnt <= load_cnt + 1;
        cap_last <= last_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    @(negedge clk);
    wr_cnt = 0; busy_cyc = 0; load_cnt = 0;
  endtask

  task automatic do_start(input logic [AW-1:0] a);
    @(negedge clk); wr_start = 1'b1; wr_base = a;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic send(input logic [DW-1:0] d);
    @(negedge clk); byte_vld = 1'b1; byte_data = d;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic do_stop(input logic prot);
    @(negedge clk); stop = 1'b1; wp = prot;
    @(negedge clk); stop = 1'b0; wp = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy, "R13 busy", busy, 0);
    chk(!arr_we, "R13 arr_we", arr_we, 0);
    chk(!addr_load, "R13 addr_load", addr_load, 0);
  endtask

  task automatic t_byte_write();
    clr_log();
    do_start(11'h123);
    send(8'hA5);
    repeat (4) @(negedge clk);
    chk(wr_cnt == 0, "R3 no write before stop", wr_cnt, 0);
    do_stop(1'b0);
    wait_idle();
    chk(wr_cnt == 1, "R1 byte write count", wr_cnt, 1);
    chk(mem_m[11'h123] == 8'hA5, "R1 byte data", mem_m[11'h123], 8'hA5);
    chk(busy_cyc == WRC, "R5 busy length", busy_cyc, WRC);
    chk(load_cnt == 1 && cap_last == 11'h123, "R7 last addr byte", cap_last, 11'h123);
  endtask

  task automatic t_page();
    clr_log();
    do_start(11'h230);
    for (int i = 0; i < 16; i++) send(8'(8'h40 + i));
    do_stop(1'b0);
    wait_idle();
    chk(wr_cnt == 16, "R1 page count", wr_cnt, 16);
    for (int i = 0; i < 16; i++)
      chk(mem_m[11'h230 + i] == 8'(8'h40 + i), "R1 page data", mem_m[11'h230 + i], 8'h40 + i);
    chk(cap_last == 11'h23F, "R7 last addr page", cap_last, 11'h23F);
  endtask

  task automatic t_wrap();
    mem_m[11'h480] = 8'h00;
    clr_log();
    do_start(11'h47C);
    for (int i = 0; i < 6; i++) send(8'(8'h90 + i));
    do_stop(1'b0);
    wait_idle();
    chk(wr_cnt == 6, "R2 wrap count", wr_cnt, 6);
    chk(mem_m[11'h47F] == 8'h93, "R2 end of page", mem_m[11'h47F], 8'h93);
    chk(mem_m[11'h470] == 8'h94, "R2 wrap to page start", mem_m[11'h470], 8'h94);
    chk(mem_m[11'h471] == 8'h95, "R2 wrap second", mem_m[11'h471], 8'h95);
    chk(mem_m[11'h480] == 8'h00, "R2 next page untouched", mem_m[11'h480], 0);
    chk(cap_last == 11'h471, "R7 last addr after wrap", cap_last, 11'h471);
  endtask

  task automatic t_overflow();
    clr_log();
    do_start(11'h500);
    for (int i = 0; i < 18; i++) send(8'(8'h10 + i));
    do_stop(1'b0);
    wait_idle();
    chk(wr_cnt == 16, "R8 one write per offset", wr_cnt, 16);
    chk(mem_m[11'h500] == 8'h20, "R8 offset0 overwritten", mem_m[11'h500], 8'h20);
    chk(mem_m[11'h501] == 8'h21, "R8 offset1 overwritten", mem_m[11'h501], 8'h21);
    chk(mem_m[11'h502] == 8'h12, "R8 offset2 kept", mem_m[11'h502], 8'h12);
    chk(cap_last == 11'h501, "R7 last addr overflow", cap_last, 11'h501);
  endtask

  task automatic t_partial();
    clr_log();
    do_start(11'h600);
    for (int i = 0; i < 16; i++) send(8'hEE);
    do_stop(1'b0);
    wait_idle();
    clr_log();
    do_start(11'h605);
    send(8'h11); send(8'h22); send(8'h33);
    do_stop(1'b0);
    wait_idle();
    chk(wr_cnt == 3, "R9 only received written", wr_cnt, 3);
    chk(mem_m[11'h604] == 8'hEE, "R9 below kept", mem_m[11'h604], 8'hEE);
    chk(mem_m[11'h608] == 8'hEE, "R9 above kept", mem_m[11'h608], 8'hEE);
    chk(mem_m[11'h607] == 8'h33, "R9 last byte", mem_m[11'h607], 8'h33);
  endtask

  task automatic t_protect();
    clr_log();
    do_start(11'h700);
    send(8'h77);
    do_stop(1'b1);
    wait_idle();
    chk(wr_cnt == 0, "R4 wp no write", wr_cnt, 0);
    chk(busy_cyc == 0, "R4 wp no busy", busy_cyc, 0);
    chk(load_cnt == 0, "R4 wp no addr load", load_cnt, 0);
  endtask

  task automatic t_abort();
    clr_log();
    do_start(11'h710);
    send(8'h01); send(8'h02);
    do_abort();
    do_stop(1'b0);
    wait_idle();
    chk(wr_cnt == 0, "R6 abort discards", wr_cnt, 0);
    chk(busy_cyc == 0, "R6 abort no busy", busy_cyc, 0);
  endtask

  task automatic t_empty_stop();
    clr_log();
    do_start(11'h720);
    do_stop(1'b0);
    wait_idle();
    chk(wr_cnt == 0 && busy_cyc == 0, "R12 empty stop", wr_cnt + busy_cyc, 0);
  endtask

  task automatic t_restart();
    clr_log();
    do_start(11'h730);
    send(8'hAA); send(8'hBB);
    do_start(11'h738);
    send(8'hCC);
    do_stop(1'b0);
    wait_idle();
    chk(wr_cnt == 1, "R11 restart count", wr_cnt, 1);
    chk(mem_m[11'h738] == 8'hCC, "R11 new base data", mem_m[11'h738], 8'hCC);
  endtask

  task automatic t_busy_ignore();
    clr_log();
    do_start(11'h740);
    send(8'h5A);
    do_stop(1'b0);
    repeat (3) @(negedge clk);
    do_start(11'h750);
    send(8'h66);
    do_stop(1'b0);
    wait_idle();
    chk(wr_cnt == 1, "R10 inputs ignored while busy", wr_cnt, 1);
    chk(busy_cyc == WRC, "R10 single busy window", busy_cyc, WRC);
    chk(mem_m[11'h740] == 8'h5A, "R10 first write kept", mem_m[11'h740], 8'h5A);
  endtask

  initial begin
    for (int i = 0; i < 2**AW; i++) mem_m[i] = 8'h00;
    rst_n = 1'b0; wr_start = 1'b0; byte_vld = 1'b0; stop = 1'b0;
    abort = 1'b0; wp = 1'b0; wr_base = '0; byte_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_byte_write();
    t_page();
    t_wrap();
    t_overflow();
    t_partial();
    t_protect();
    t_abort();
    t_empty_stop();
    t_restart();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule